// File: doc/BRIEF.md
# Parallel-Port Unlock Sequence Detector

This block sits on the device side of a bridge between a host parallel port and a disk interface. The host writes bytes onto the data lines and toggles the control lines. The block watches both. It looks for a fixed seven-byte unlock preamble, then takes the byte that follows as a command. The command is carried out only after a control-line handshake and a closing all-ones byte. A recognised command yields a one-cycle strobe (connect, disconnect or neutral idle) and updates a connected flag that the rest of the bridge uses to open register access.

During the preamble the block returns an identifier on a 4-bit status nibble, one piece at a time. Host software reads the pieces back to confirm that the expected bridge is present. Any byte out of order drops the match. Any unexpected control change during the handshake also drops the match. A stray byte equal to the first preamble byte counts as a fresh start.

All outputs are registered. Each one reflects an input event in the clock cycle after the edge that sampled that event.

Top module: `ppu_unlock_det`

## Requirements
- R1: After reset, `link_up`, `go_connect`, `go_disconnect` and `go_idle` are 0 and `id_nibble` is 0x0.
- R2: The preamble is the byte sequence 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78 on valid bytes. The next valid byte is latched as the command. Control must then rise from 0x4 to 0x5 and fall back to 0x4, and the next valid byte must be 0xFF. Only then does the command take effect, with its strobe high in the cycle after that 0xFF is sampled.
- R3: Command 0x20 pulses `go_connect` and sets `link_up`.
- R4: Command 0x30 pulses `go_disconnect` and clears `link_up`.
- R5: Command 0x00 pulses `go_idle` and leaves `link_up` unchanged. Any other command value produces no strobe and leaves `link_up` unchanged.
- R6: `id_nibble` reads 0xB after the fifth preamble byte (0xFF). It reads 0x5 after the sixth byte, after the seventh byte and while the command waits for control to reach 0x5. It reads 0xF from the rise of control to 0x5 until completion if the command is 0x20; otherwise it stays 0x5 over that span. In all other states it reads 0x0.
- R7: A valid byte that does not match the expected preamble byte restarts matching. If that byte is 0xFE, it counts as the first preamble byte.
- R8: A valid byte during the control handshake, or a closing byte other than 0xFF, abandons the command with no strobe. The R7 restart rule applies to that byte.
- R9: During the handshake, a control change to any value other than the one expected next abandons the command with no strobe and resets the match to its start.
- R10: Strobes last exactly one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_byte | input | 8 | Byte latched from host data lines |
| host_byte_vld | input | 1 | One-cycle qualifier: host_byte is a new write |
| host_ctrl | input | 4 | Current level of host control lines |
| link_up | output | 1 | Connected flag |
| go_connect | output | 1 | Connect command strobe |
| go_disconnect | output | 1 | Disconnect command strobe |
| go_idle | output | 1 | Neutral command strobe |
| id_nibble | output | 4 | Value driven on upper status lines |

## Verification
The bound checker enforces the strobe rules on every cycle: strobes are one-hot and single-cycle, and each follows a sampled 0xFF byte. It also checks that the connected flag moves only together with a connect or disconnect strobe, and that the status nibble only ever shows one of the four legal values. The order of the preamble, the FE restart, the staged 0xB/0x5/0xF identifier and the abort paths during the handshake depend on whole byte and control sequences. Only the bench scenarios exercise these, comparing each strobe against a queue of expected commands.

// File: rtl/ppu_unlock_pkg.sv
package ppu_unlock_pkg;

    localparam int PRE_LEN = 7;

    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,
        PH_CMD_LO = 2'd1,
        PH_CMD_HI = 2'd2,
        PH_FINAL = 2'd3
    } phase_t;

    // Preamble byte expected at a given matched count.
    function automatic logic [7:0] pre_byte(input int idx);
        case (idx)
            0: pre_byte = 8'hFE;
            1: pre_byte = 8'hAA;
            2: pre_byte = 8'h55;
            3: pre_byte = 8'h00;
            4: pre_byte = 8'hFF;
            5: pre_byte = 8'h87;
            6: pre_byte = 8'h78;
            default: pre_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ppu_ctrl_change.sv
module ppu_ctrl_change #(
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] level,
    output logic              chg,
    output logic [CTRL_W-1:0] prev
);
    logic [CTRL_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign prev = prev_q;
    assign chg  = (level != prev_q);
endmodule

// File: rtl/ppu_pre_cmp.sv
module ppu_pre_cmp
    import ppu_unlock_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic [CNT_W-1:0]  idx,
    input  logic [DATA_W-1:0] byte_in,
    output logic              hit,
    output logic              is_head
);
    logic [DATA_W-1:0] want;
    logic [DATA_W-1:0] head;

    always_comb begin
        want    = DATA_W'(pre_byte(int'(idx)));
        head    = DATA_W'(pre_byte(0));
        hit     = (byte_in == want) && (int'(idx) < PRE_LEN);
        is_head = (byte_in == head);
    end
endmodule

// File: rtl/ppu_cmd_decode.sv
module ppu_cmd_decode #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  CODE_CON = 8'h20,
    parameter logic [7:0]  CODE_DIS = 8'h30,
    parameter logic [7:0]  CODE_IDL = 8'h00
) (
    input  logic [DATA_W-1:0] cmd,
    input  logic              fire,
    output logic              do_con,
    output logic              do_dis,
    output logic              do_idl
);
    always_comb begin
        do_con = fire && (cmd == DATA_W'(CODE_CON));
        do_dis = fire && (cmd == DATA_W'(CODE_DIS));
        do_idl = fire && (cmd == DATA_W'(CODE_IDL));
    end
endmodule

// File: rtl/ppu_unlock_det.sv
module ppu_unlock_det
    import ppu_unlock_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter int         CTRL_W   = 4,
    parameter int         STAT_W   = 4,
    parameter logic [7:0] CODE_CON = 8'h20,
    parameter logic [7:0] CODE_DIS = 8'h30,
    parameter logic [7:0] CODE_IDL = 8'h00,
    parameter int         CTRL_LO  = 4,
    parameter int         CTRL_HI  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_byte,
    input  logic              host_byte_vld,
    input  logic [CTRL_W-1:0] host_ctrl,
    output logic              link_up,
    output logic              go_connect,
    output logic              go_disconnect,
    output logic              go_idle,
    output logic [STAT_W-1:0] id_nibble
);
    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam logic [STAT_W-1:0] ID_A    = STAT_W'(4'hB);
    localparam logic [STAT_W-1:0] ID_B    = STAT_W'(4'h5);
    localparam logic [STAT_W-1:0] ID_C    = STAT_W'(4'hF);
    localparam logic [STAT_W-1:0] ID_NONE = STAT_W'(4'h0);
    localparam int ID_A_AT = 5;
    localparam int ID_B_AT = 6;
    localparam logic [DATA_W-1:0] CLOSE_BYTE = '1;

    typedef struct packed {
        phase_t              ph;
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-1:0]   cmd;
        logic                up;
        logic                s_con;
        logic                s_dis;
        logic                s_idl;
        logic [STAT_W-1:0]   stat;
    } st_t;

    st_t st_d, st_q;

    logic              ctrl_chg;
    logic [CTRL_W-1:0] ctrl_prev;
    logic              pre_hit, pre_head;
    logic              fire;
    logic              do_con, do_dis, do_idl;

    ppu_ctrl_change #(.CTRL_W(CTRL_W)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .level (host_ctrl),
        .chg   (ctrl_chg),
        .prev  (ctrl_prev)
    );

    ppu_pre_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
        .idx     (st_q.cnt),
        .byte_in (host_byte),
        .hit     (pre_hit),
        .is_head (pre_head)
    );

    ppu_cmd_decode #(
        .DATA_W   (DATA_W),
        .CODE_CON (CODE_CON),
        .CODE_DIS (CODE_DIS),
        .CODE_IDL (CODE_IDL)
    ) u_dec (
        .cmd    (st_q.cmd),
        .fire   (fire),
        .do_con (do_con),
        .do_dis (do_dis),
        .do_idl (do_idl)
    );

    always_comb begin
        fire = host_byte_vld && (st_q.ph == PH_FINAL) && (host_byte == CLOSE_BYTE);
    end

    always_comb begin
        st_d       = st_q;
        st_d.s_con = 1'b0;
        st_d.s_dis = 1'b0;
        st_d.s_idl = 1'b0;

        if (host_byte_vld) begin
            if (st_q.ph == PH_HUNT && int'(st_q.cnt) == PRE_LEN) begin
                st_d.cmd = host_byte;
                st_d.ph  = PH_CMD_LO;
                st_d.cnt = '0;
            end else if (st_q.ph == PH_HUNT && pre_hit) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (fire) begin
                st_d.ph  = PH_HUNT;
                st_d.cnt = '0;
            end else begin
                // out-of-order byte: restart, leading byte counts as step one
                st_d.ph  = PH_HUNT;
                st_d.cnt = pre_head ? CNT_W'(1) : '0;
            end
        end else if (ctrl_chg) begin
            case (st_q.ph)
                PH_CMD_LO: begin
                    if (host_ctrl == CTRL_W'(CTRL_HI) && ctrl_prev == CTRL_W'(CTRL_LO)) begin
                        st_d.ph = PH_CMD_HI;
                    end else if (host_ctrl != CTRL_W'(CTRL_LO)) begin
                        st_d.ph  = PH_HUNT;
                        st_d.cnt = '0;
                    end
                end
                PH_CMD_HI: begin
                    if (host_ctrl == CTRL_W'(CTRL_LO)) begin
                        st_d.ph = PH_FINAL;
                    end else begin
                        st_d.ph  = PH_HUNT;
                        st_d.cnt = '0;
                    end
                end
                PH_FINAL: begin
                    st_d.ph  = PH_HUNT;
                    st_d.cnt = '0;
                end
                default: ;
            endcase
        end

        if (do_con) begin
            st_d.s_con = 1'b1;
            st_d.up    = 1'b1;
        end
        if (do_dis) begin
            st_d.s_dis = 1'b1;
            st_d.up    = 1'b0;
        end
        if (do_idl) begin
            st_d.s_idl = 1'b1;
        end

        case (st_d.ph)
            PH_HUNT: begin
                if (int'(st_d.cnt) == ID_A_AT)      st_d.stat = ID_A;
                else if (int'(st_d.cnt) >= ID_B_AT) st_d.stat = ID_B;
                else                                st_d.stat = ID_NONE;
            end
            PH_CMD_LO: st_d.stat = ID_B;
            default:   st_d.stat = (st_d.cmd == DATA_W'(CODE_CON)) ? ID_C : ID_B;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_HUNT, cnt: '0, cmd: '0, up: 1'b0,
                      s_con: 1'b0, s_dis: 1'b0, s_idl: 1'b0, stat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign link_up       = st_q.up;
    assign go_connect    = st_q.s_con;
    assign go_disconnect = st_q.s_dis;
    assign go_idle       = st_q.s_idl;
    assign id_nibble     = st_q.stat;
endmodule

// File: rtl/ppu_unlock_det_chk.sv
module ppu_unlock_det_chk #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] host_byte,
    input logic              host_byte_vld,
    input logic              link_up,
    input logic              go_connect,
    input logic              go_disconnect,
    input logic              go_idle,
    input logic [STAT_W-1:0] id_nibble
);
    p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_connect, go_disconnect, go_idle}));

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_connect || go_disconnect || go_idle) |=> !(go_connect || go_disconnect || go_idle));

    p_strobe_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_connect || go_disconnect || go_idle) |-> $past(host_byte_vld && host_byte == '1));

    p_connect_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_connect |-> link_up);

    p_disconnect_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go_disconnect |-> !link_up);

    p_flag_moves_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_up) |-> (go_connect || go_disconnect));

    p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_nibble == STAT_W'(4'h0)) || (id_nibble == STAT_W'(4'hB)) ||
        (id_nibble == STAT_W'(4'h5)) || (id_nibble == STAT_W'(4'hF)));
endmodule

bind ppu_unlock_det ppu_unlock_det_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_byte     (host_byte),
    .host_byte_vld (host_byte_vld),
    .link_up       (link_up),
    .go_connect    (go_connect),
    .go_disconnect (go_disconnect),
    .go_idle       (go_idle),
    .id_nibble     (id_nibble)
);

// File: tb/ppu_unlock_det_tb.sv
`timescale 1ns/1ps
module ppu_unlock_det_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       host_byte_vld = 1'b0;
    logic [3:0] host_ctrl = 4'h4;
    logic       link_up, go_connect, go_disconnect, go_idle;
    logic [3:0] id_nibble;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected strobe codes: 4 = connect, 2 = disconnect, 1 = idle
    int exp_q[$];

    always #4 clk = ~clk;

    ppu_unlock_det dut_i (
        .clk(clk), .rst_n(rst_n), .host_byte(host_byte), .host_byte_vld(host_byte_vld),
        .host_ctrl(host_ctrl), .link_up(link_up), .go_connect(go_connect),
        .go_disconnect(go_disconnect), .go_idle(go_idle), .id_nibble(id_nibble)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        host_byte = b;
        host_byte_vld = 1'b1;
        @(negedge clk);
        host_byte_vld = 1'b0;
    endtask

    task automatic set_ctrl(input logic [3:0] v);
        @(negedge clk);
        host_ctrl = v;
        @(negedge clk);
    endtask

    task automatic preamble();
        send_byte(8'hFE); send_byte(8'hAA); send_byte(8'h55); send_byte(8'h00);
        send_byte(8'hFF); send_byte(8'h87); send_byte(8'h78);
    endtask

    task automatic full_cmd(input logic [7:0] c);
        preamble();
        send_byte(c);
        set_ctrl(4'h4);
        set_ctrl(4'h5);
        set_ctrl(4'h4);
        send_byte(8'hFF);
    endtask

    // monitor: pops one expected item per observed strobe
    always @(negedge clk) begin
        if (rst_n && (go_connect || go_disconnect || go_idle)) begin
            int code;
            code = {29'd0, go_connect, go_disconnect, go_idle};
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", code, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(code == e, "R2 strobe kind", code, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(link_up == 1'b0, "R1 link_up", link_up, 0);
        check({go_connect, go_disconnect, go_idle} == 3'b000, "R1 strobes",
              {go_connect, go_disconnect, go_idle}, 0);
        check(id_nibble == 4'h0, "R1 id_nibble", id_nibble, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 staged identifier with connect command, R3 connect
        send_byte(8'hFE); send_byte(8'hAA); send_byte(8'h55); send_byte(8'h00);
        check(id_nibble == 4'h0, "R6 before fifth byte", id_nibble, 0);
        send_byte(8'hFF);
        check(id_nibble == 4'hB, "R6 after FF", id_nibble, 4'hB);
        send_byte(8'h87);
        check(id_nibble == 4'h5, "R6 after 87", id_nibble, 4'h5);
        send_byte(8'h78);
        send_byte(8'h20);
        check(id_nibble == 4'h5, "R6 command held", id_nibble, 4'h5);
        set_ctrl(4'h4);
        set_ctrl(4'h5);
        check(id_nibble == 4'hF, "R6 ctrl high with 20", id_nibble, 4'hF);
        set_ctrl(4'h4);
        exp_q.push_back(4);
        send_byte(8'hFF);
        check(link_up == 1'b1, "R3 link_up set", link_up, 1);
        check(go_connect == 1'b1, "R2 strobe next cycle", go_connect, 1);
        @(negedge clk);
        check(go_connect == 1'b0, "R10 strobe one cycle", go_connect, 0);
        check(id_nibble == 4'h0, "R6 neutral after done", id_nibble, 0);

        // R5 neutral command
        exp_q.push_back(1);
        full_cmd(8'h00);
        check(link_up == 1'b1, "R5 idle keeps link", link_up, 1);

        // R5 unknown command, and R6 stays 5 when command is not 20
        preamble();
        send_byte(8'h55);
        set_ctrl(4'h5);
        check(id_nibble == 4'h5, "R6 ctrl high other cmd", id_nibble, 4'h5);
        set_ctrl(4'h4);
        send_byte(8'hFF);
        check(link_up == 1'b1, "R5 unknown cmd no change", link_up, 1);

        // R7 mismatch restart and FE restart at step one
        send_byte(8'hFE); send_byte(8'hAA); send_byte(8'h13);
        send_byte(8'h00); send_byte(8'hFF);
        check(id_nibble == 4'h0, "R7 mismatch restarts", id_nibble, 0);
        send_byte(8'hFE); send_byte(8'hAA); send_byte(8'hFE);
        send_byte(8'hAA); send_byte(8'h55); send_byte(8'h00); send_byte(8'hFF);
        check(id_nibble == 4'hB, "R7 FE counts as step one", id_nibble, 4'hB);
        send_byte(8'h87); send_byte(8'h78); send_byte(8'h30);
        set_ctrl(4'h5);
        set_ctrl(4'h4);
        exp_q.push_back(2);
        send_byte(8'hFF);
        check(link_up == 1'b0, "R4 disconnect clears", link_up, 0);

        // R8 byte inside handshake aborts
        preamble();
        send_byte(8'h20);
        set_ctrl(4'h5);
        send_byte(8'h11);
        check(id_nibble == 4'h0, "R8 byte aborts handshake", id_nibble, 0);
        set_ctrl(4'h4);
        send_byte(8'hFF);
        check(link_up == 1'b0, "R8 no connect after abort", link_up, 0);

        // R8 wrong closing byte
        preamble();
        send_byte(8'h20);
        set_ctrl(4'h5);
        set_ctrl(4'h4);
        send_byte(8'hFE);
        check(id_nibble == 4'h0, "R8 wrong close byte", id_nibble, 0);
        send_byte(8'hFF);
        check(link_up == 1'b0, "R8 no connect after bad close", link_up, 0);

        // R9 unexpected control value aborts
        preamble();
        send_byte(8'h20);
        set_ctrl(4'h6);
        check(id_nibble == 4'h0, "R9 ctrl abort", id_nibble, 0);
        set_ctrl(4'h4);
        set_ctrl(4'h5);
        set_ctrl(4'h4);
        send_byte(8'hFF);
        check(link_up == 1'b0, "R9 no connect after ctrl abort", link_up, 0);

        // final connect to show recovery
        exp_q.push_back(4);
        full_cmd(8'h20);
        check(link_up == 1'b1, "R3 connect after aborts", link_up, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule